// File: doc/BRIEF.md
# Two-to-one packing clock-crossing FIFO

This block moves sample data from one clock domain to another and doubles the word width on the way. The producer writes 128-bit words on its own clock. The consumer reads 256-bit words on an unrelated clock. Every pair of consecutive narrow writes becomes one wide read word.

Each side sees only its own flag. The writer sees a full flag and the reader sees an empty flag. Requests that arrive against the wrong flag are dropped inside the block, so a careless neighbour cannot corrupt stored samples or replay stale ones.

Pointers cross between the domains as gray code, through a chain of flip-flops whose length is a parameter. Each domain has its own asynchronous active-low reset.

The read port shows the oldest complete wide word whenever the FIFO is not empty. Raising the read request for one cycle removes that word.

Top module: `wide_pack_afifo`

## Requirements
- R1: After reset, `rd_empty` is 1 and `wr_full` is 0.
- R2: For each pair of narrow writes, the first word appears in bits [127:0] of the wide read word and the second in bits [255:128]. Wide words leave in the order they were written.
- R3: A write request while `wr_full` is 1 is dropped. Data already stored stays unchanged and is read back intact.
- R4: A read request while `rd_empty` is 1 is dropped. The read position does not advance, so the next two writes still form the next wide word.
- R5: `wr_full` rises on the write-clock edge that stores the DEPTH_WR-th narrow word with no reads. It falls within a few write clocks once a wide word has been read.
- R6: `rd_empty` stays 1 while only an odd single narrow word (half of a wide word) is waiting.
- R7: Once two narrow writes complete, `rd_empty` falls within SYNC_STAGES plus a few read clocks. Each crossing pointer changes in at most one bit per clock.
- R8: Asserting both resets while data is stored returns both pointers to zero. The FIFO then reads as empty and not full, and new data packs from the low half again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | WR_W | Narrow write word |
| wr_full | output | 1 | No room for another narrow word |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_en | input | 1 | Read request (removes the shown word) |
| rd_data | output | 2*WR_W | Oldest complete wide word |
| rd_empty | output | 1 | No complete wide word stored |

## Verification
The bench builds the block with WR_W = 128, DEPTH_WR = 16 and SYNC_STAGES = 4. The width and synchroniser length are the production values. The depth is shrunk so that filling to full, the dropped overflow write and draining back to empty all take only a few dozen cycles. With eight wide words of storage, the pointers also wrap, and the half-filled odd state is reached often.

// File: rtl/wpk_pkg.sv
package wpk_pkg;
   // Pointer width for a given write-side depth: address bits plus one wrap bit.
   function automatic int ptr_bits(input int depth);
      return $clog2(depth) + 1;
   endfunction
endpackage

// File: rtl/wpk_sync.sv
module wpk_sync #(
   parameter int W      = 4,
   parameter int STAGES = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/wpk_store.sv
module wpk_store #(
   parameter int WR_W = 128,
   parameter int ROWS = 8,
   parameter int RA_W = 3
) (
   input  logic              wr_clk,
   input  logic              wr_we,
   input  logic              wr_sel,
   input  logic [RA_W-1:0]   wr_row,
   input  logic [WR_W-1:0]   wr_data,
   input  logic [RA_W-1:0]   rd_row,
   output logic [2*WR_W-1:0] rd_data
);
   // Bank 0 holds even-numbered narrow writes (low half), bank 1 the odd ones.
   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [WR_W-1:0] cells [ROWS];
      always_ff @(posedge wr_clk) begin
         if (wr_we && (wr_sel == 1'(b))) cells[wr_row] <= wr_data;
      end
      assign rd_data[b*WR_W +: WR_W] = cells[rd_row];
   end
endmodule

// File: rtl/wpk_wr_ctl.sv
module wpk_wr_ctl #(
   parameter int DEPTH = 16,
   parameter int AW    = 5
) (
   input  logic          wr_clk,
   input  logic          wr_rst_n,
   input  logic          wr_en,
   input  logic [AW-2:0] rd_gray_s,
   output logic          full,
   output logic          we,
   output logic [AW-1:0] wr_ptr,
   output logic [AW-1:0] wr_gray
);
   logic [AW-2:0] rd_bin;
   logic [AW-1:0] rd_in_wr_units, fill, wr_ptr_n;

   always_comb begin
      rd_bin[AW-2] = rd_gray_s[AW-2];
      for (int i = AW-3; i >= 0; i--) rd_bin[i] = rd_bin[i+1] ^ rd_gray_s[i];
   end

   assign rd_in_wr_units = {rd_bin, 1'b0};
   assign fill           = wr_ptr - rd_in_wr_units;
   assign full           = (fill == AW'(DEPTH));
   assign we             = wr_en && !full;
   assign wr_ptr_n       = wr_ptr + AW'(1);

   always_ff @(posedge wr_clk or negedge wr_rst_n) begin
      if (!wr_rst_n) begin
         wr_ptr  <= '0;
         wr_gray <= '0;
      end else if (we) begin
         wr_ptr  <= wr_ptr_n;
         wr_gray <= wr_ptr_n ^ (wr_ptr_n >> 1);
      end
   end

   assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (wr_en && full) |=> $stable(wr_ptr));
   assert_fill_bound_R5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      fill <= AW'(DEPTH));
   assert_gray_step_R7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      $countones(wr_gray ^ $past(wr_gray)) <= 1);
endmodule

// File: rtl/wpk_rd_ctl.sv
module wpk_rd_ctl #(
   parameter int AW = 5
) (
   input  logic          rd_clk,
   input  logic          rd_rst_n,
   input  logic          rd_en,
   input  logic [AW-1:0] wr_gray_s,
   output logic          empty,
   output logic [AW-2:0] rd_ptr,
   output logic [AW-2:0] rd_gray
);
   logic [AW-1:0] wr_bin, avail;
   logic [AW-2:0] rd_ptr_n;
   logic          re;

   always_comb begin
      wr_bin[AW-1] = wr_gray_s[AW-1];
      for (int i = AW-2; i >= 0; i--) wr_bin[i] = wr_bin[i+1] ^ wr_gray_s[i];
   end

   // A wide word needs two narrow entries.
   assign avail    = wr_bin - {rd_ptr, 1'b0};
   assign empty    = (avail[AW-1:1] == '0);
   assign re       = rd_en && !empty;
   assign rd_ptr_n = rd_ptr + (AW-1)'(1);

   always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n) begin
         rd_ptr  <= '0;
         rd_gray <= '0;
      end else if (re) begin
         rd_ptr  <= rd_ptr_n;
         rd_gray <= rd_ptr_n ^ (rd_ptr_n >> 1);
      end
   end

   assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (rd_en && empty) |=> $stable(rd_ptr));
   assert_gray_step_rd_R7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      $countones(rd_gray ^ $past(rd_gray)) <= 1);
endmodule

// File: rtl/wide_pack_afifo.sv
module wide_pack_afifo #(
   parameter int WR_W        = 128,
   parameter int DEPTH_WR    = 2048,
   parameter int SYNC_STAGES = 4
) (
   input  logic              wr_clk,
   input  logic              wr_rst_n,
   input  logic              wr_en,
   input  logic [WR_W-1:0]   wr_data,
   output logic              wr_full,
   input  logic              rd_clk,
   input  logic              rd_rst_n,
   input  logic              rd_en,
   output logic [2*WR_W-1:0] rd_data,
   output logic              rd_empty
);
   localparam int AW   = wpk_pkg::ptr_bits(DEPTH_WR);
   localparam int ROWS = DEPTH_WR / 2;
   localparam int RA_W = AW - 2;

   if (DEPTH_WR < 4 || (DEPTH_WR & (DEPTH_WR - 1)) != 0) begin : g_bad_depth
      $error("DEPTH_WR must be a power of two of at least 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (WR_W < 1) begin : g_bad_width
      $error("WR_W must be positive");
   end

   logic [AW-1:0] wr_ptr, wr_gray, wr_gray_s;
   logic [AW-2:0] rd_ptr, rd_gray, rd_gray_s;
   logic          we;

   wpk_wr_ctl #(.DEPTH(DEPTH_WR), .AW(AW)) wr_ctl_i (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .rd_gray_s(rd_gray_s),
      .full(wr_full), .we(we), .wr_ptr(wr_ptr), .wr_gray(wr_gray));

   wpk_rd_ctl #(.AW(AW)) rd_ctl_i (
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .wr_gray_s(wr_gray_s),
      .empty(rd_empty), .rd_ptr(rd_ptr), .rd_gray(rd_gray));

   wpk_sync #(.W(AW), .STAGES(SYNC_STAGES)) w2r_i (
      .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray), .q(wr_gray_s));

   wpk_sync #(.W(AW-1), .STAGES(SYNC_STAGES)) r2w_i (
      .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray), .q(rd_gray_s));

   wpk_store #(.WR_W(WR_W), .ROWS(ROWS), .RA_W(RA_W)) store_i (
      .wr_clk(wr_clk), .wr_we(we), .wr_sel(wr_ptr[0]), .wr_row(wr_ptr[AW-2:1]),
      .wr_data(wr_data), .rd_row(rd_ptr[RA_W-1:0]), .rd_data(rd_data));

   assert_reset_flags_R1: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      $rose(rd_rst_n) |-> rd_empty);
endmodule

// File: tb/wide_pack_afifo_tb_top.sv
`timescale 1ns/100ps
module wide_pack_afifo_tb_top;
   localparam int W = 128;
   localparam int D = 16;
   localparam int S = 4;

   logic wr_clk = 0, rd_clk = 0, wr_rst_n = 0, rd_rst_n = 0;
   logic wr_en = 0, rd_en = 0;
   logic [W-1:0]   wr_data = '0;
   logic [2*W-1:0] rd_data;
   logic wr_full, rd_empty;
   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   always #4 wr_clk = ~wr_clk;     // 125 MHz
   always #5.5 rd_clk = ~rd_clk;

   wide_pack_afifo #(.WR_W(W), .DEPTH_WR(D), .SYNC_STAGES(S)) dut_i (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wr_full(wr_full), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
      .rd_data(rd_data), .rd_empty(rd_empty));

   function automatic logic [W-1:0] mk(input int i);
      return {32'hA5C30000 + 32'(i), 32'(i) * 32'd7, ~32'(i), 32'h0F000000 | 32'(i)};
   endfunction

   task automatic check(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic push(input int i);
      @(negedge wr_clk); wr_en = 1; wr_data = mk(i);
      @(negedge wr_clk); wr_en = 0;
   endtask

   task automatic settle();
      repeat (S + 4) @(negedge wr_clk);
      repeat (S + 4) @(negedge rd_clk);
   endtask

   task automatic pop_expect(input string req, input int first);
      @(negedge rd_clk);
      check(req, {255'b0, rd_empty}, 256'd0);
      check(req, rd_data, {mk(first + 1), mk(first)});
      rd_en = 1;
      @(negedge rd_clk); rd_en = 0;
   endtask

   task automatic do_reset();
      wr_en = 0; rd_en = 0;
      #3; wr_rst_n = 0; rd_rst_n = 0;
      #20; wr_rst_n = 1; rd_rst_n = 1;
      settle();
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 empty", {255'b0, rd_empty}, 256'd1);
      check("R1 full", {255'b0, wr_full}, 256'd0);
   endtask

   task automatic t_half_then_pack();
      push(0);
      settle();
      check("R6 one narrow word stays empty", {255'b0, rd_empty}, 256'd1);
      push(1);
      repeat (S + 3) @(negedge rd_clk);
      check("R7 empty falls after second write", {255'b0, rd_empty}, 256'd0);
      pop_expect("R2 low/high packing", 0);
      settle();
      check("R2 empty after pop", {255'b0, rd_empty}, 256'd1);
   endtask

   task automatic t_order();
      for (int i = 10; i < 16; i++) push(i);
      settle();
      for (int k = 0; k < 3; k++) pop_expect("R2 order", 10 + 2*k);
      settle();
      check("R2 drained", {255'b0, rd_empty}, 256'd1);
   endtask

   task automatic t_full();
      for (int i = 0; i < D - 1; i++) push(100 + i);
      @(negedge wr_clk);
      check("R5 not full at D-1", {255'b0, wr_full}, 256'd0);
      push(100 + D - 1);
      check("R5 full at D", {255'b0, wr_full}, 256'd1);
      push(999);   // dropped
      check("R3 still full", {255'b0, wr_full}, 256'd1);
      settle();
      pop_expect("R5 first wide word", 100);
      settle();
      check("R5 full falls after read", {255'b0, wr_full}, 256'd0);
      for (int k = 1; k < D/2; k++) pop_expect("R3 contents intact", 100 + 2*k);
      settle();
      check("R3 empty after drain", {255'b0, rd_empty}, 256'd1);
   endtask

   task automatic t_underflow();
      @(negedge rd_clk); rd_en = 1;
      repeat (5) @(negedge rd_clk);
      rd_en = 0;
      check("R4 still empty", {255'b0, rd_empty}, 256'd1);
      push(200); push(201);
      settle();
      pop_expect("R4 next pair unaffected", 200);
      settle();
   endtask

   task automatic t_reset_mid();
      push(300); push(301); push(302); push(303); push(304);
      settle();
      do_reset();
      check("R8 empty after reset", {255'b0, rd_empty}, 256'd1);
      check("R8 not full after reset", {255'b0, wr_full}, 256'd0);
      push(400); push(401);
      settle();
      pop_expect("R8 packing restarts at low half", 400);
   endtask

   initial begin
      t_reset();
      t_half_then_pack();
      t_order();
      t_full();
      t_underflow();
      t_reset_mid();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule